// File: doc/BRIEF.md
# Eight-Byte Serial Word Transmitter

This block sends a wide data word, by default 64 bits, over one asynchronous serial line as a train of byte frames. A single start strobe captures the word and the chosen parity mode. The block then sends every byte of the word, lowest byte first, with no idle time between frames.

Each frame has these bits, in order:
- one start bit at 0;
- eight data bits, least significant first;
- one parity bit;
- two stop bits at 1.

The parity bit is the XOR of the byte's eight data bits. For odd parity the result is also XOR'd with 1.

The baud rate is fixed when the block is built. An internal divider sets how many system clocks each line bit lasts. A busy flag tells the surrounding logic when it may start the next word.

Top module: `serial_word_tx`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, `txLine` is 1 and `busy` is 0.
- R2: Each frame is one 0 start bit, then eight data bits least significant bit first, then one parity bit, then two 1 stop bits. Every bit holds the line for exactly `CLKS_PER_BIT` clock cycles.
- R3: The word goes out as `NUM_BYTES` frames. Bits 7:0 go first and the top byte goes last. Each start bit follows the previous frame's second stop bit immediately, so frame starts are 12·`CLKS_PER_BIT` cycles apart.
- R4: With `oddParity` = 0 at the strobe, the parity bit equals the XOR of the eight data bits of that frame.
- R5: With `oddParity` = 1 at the strobe, the parity bit is the inverse of the XOR of the eight data bits.
- R6: `wordIn` and `oddParity` are sampled only on the clock edge that accepts the strobe. Changing them later has no effect on the frames being sent.
- R7: A strobe seen while `busy` is 1 is ignored. It produces no extra frame and does not alter the current transfer.
- R8: `busy` rises on the clock edge that accepts a strobe and stays high for `NUM_BYTES`·12·`CLKS_PER_BIT` cycles, then falls. While `busy` is 0 the line rests at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startStb | input | 1 | One-cycle request to send `wordIn`; accepted only while idle |
| wordIn | input | 64 | Word to transmit; byte 0 in bits 7:0 |
| oddParity | input | 1 | Parity mode: 0 gives even parity, 1 gives odd parity |
| txLine | output | 1 | Serial output; rests at 1 |
| busy | output | 1 | High while a word is being sent |

## Verification
The words sent are:
- all zeros, which shows whether the parity seed alone decides the parity bit;
- all ones;
- an ascending byte ramp, in which every byte value differs, so a wrong byte order or a reversed bit order gives a mismatch;
- an alternating 0x55/0xAA word, which shows bit-order faults inside a byte.

Each data pattern is sent in both parity modes. The alternating-pattern transfer is also disturbed while it runs: the word input changes, the parity mode flips and a second strobe arrives. This separates correct capture at the strobe from designs that read the live inputs or accept a new request while busy. The spacing between frame start bits is measured to confirm that the frames run back to back.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PARITY, ST_STOP1, ST_STOP2
  } txState_e;

  typedef enum logic [2:0] {
    LN_REST, LN_START, LN_DATA, LN_PARITY, LN_STOP
  } lineSel_e;

  typedef struct packed {
    logic                 load;
    logic                 nextByte;
    lineSel_e             lineSel;
    logic [BIT_IDX_W-1:0] bitSel;
  } txCtl_t;
endpackage

// File: rtl/sertx_datapath.sv
module sertx_datapath
  import sertx_pkg::*;
#(
  parameter int NUM_BYTES = 8,
  localparam int WORD_W = NUM_BYTES * BYTE_W,
  localparam int IDX_W  = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  txCtl_t            ctl,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              oddParity,
  output logic              lastByte,
  output logic              txLine
);
  logic [WORD_W-1:0] wordReg;
  logic              oddReg;
  logic [IDX_W-1:0]  byteIdx;
  logic [BYTE_W-1:0] byteArr [NUM_BYTES];
  logic [BYTE_W-1:0] curByte;
  logic              parBit;

  for (genvar g = 0; g < NUM_BYTES; g++) begin : gSlice
    assign byteArr[g] = wordReg[g*BYTE_W +: BYTE_W];
  end

  assign curByte  = byteArr[byteIdx];
  assign parBit   = (^curByte) ^ oddReg;
  assign lastByte = (byteIdx == IDX_W'(NUM_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      wordReg <= '0;
      oddReg  <= 1'b0;
      byteIdx <= '0;
    end else if (ctl.load) begin
      wordReg <= wordIn;
      oddReg  <= oddParity;
      byteIdx <= '0;
    end else if (ctl.nextByte) begin
      byteIdx <= byteIdx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txLine <= 1'b1;
    end else begin
      unique case (ctl.lineSel)
        LN_START:  txLine <= 1'b0;
        LN_DATA:   txLine <= curByte[ctl.bitSel];
        LN_PARITY: txLine <= parBit;
        default:   txLine <= 1'b1;
      endcase
    end
  end

  // R1
  resetLineHigh_chk: assert property (@(posedge clk) rst |=> txLine);

  // R6
  wordHeld_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(wordReg) && $stable(oddReg));

  // R3
  byteStep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.nextByte |=> byteIdx == $past(byteIdx) + 1'b1);
endmodule

// File: rtl/sertx_control.sv
module sertx_control
  import sertx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   startStb,
  input  logic   lastByte,
  output txCtl_t ctl,
  output logic   busy
);
  txState_e             state;
  logic [CNT_W-1:0]     baudCnt;
  logic [BIT_IDX_W-1:0] bitCnt;
  logic                 tick;

  assign tick = (baudCnt == CNT_W'(CLKS_PER_BIT - 1));
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      baudCnt <= '0;
      bitCnt  <= '0;
    end else if (state == ST_IDLE) begin
      if (startStb) begin
        state   <= ST_START;
        baudCnt <= '0;
        bitCnt  <= '0;
      end
    end else begin
      baudCnt <= tick ? '0 : baudCnt + 1'b1;
      if (tick) begin
        unique case (state)
          ST_START:  begin state <= ST_DATA; bitCnt <= '0; end
          ST_DATA:   begin
            if (bitCnt == BIT_IDX_W'(BYTE_W - 1)) state <= ST_PARITY;
            else bitCnt <= bitCnt + 1'b1;
          end
          ST_PARITY: state <= ST_STOP1;
          ST_STOP1:  state <= ST_STOP2;
          ST_STOP2:  state <= lastByte ? ST_IDLE : ST_START;
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    ctl.load     = (state == ST_IDLE) && startStb;
    ctl.nextByte = (state == ST_STOP2) && tick && !lastByte;
    ctl.bitSel   = bitCnt;
    unique case (state)
      ST_START:           ctl.lineSel = LN_START;
      ST_DATA:            ctl.lineSel = LN_DATA;
      ST_PARITY:          ctl.lineSel = LN_PARITY;
      ST_STOP1, ST_STOP2: ctl.lineSel = LN_STOP;
      default:            ctl.lineSel = LN_REST;
    endcase
  end

  // R8
  acceptStart_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startStb) |=> (state == ST_START && baudCnt == '0));

  // R2
  baudRange_chk: assert property (@(posedge clk) disable iff (rst)
    baudCnt <= CNT_W'(CLKS_PER_BIT - 1));

  // R7
  busyIgnore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && startStb && !tick) |=> $stable(state));

  // R3
  chainFrames_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STOP2 && tick && !lastByte) |=> state == ST_START);
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx
  import sertx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int NUM_BYTES    = 8,
  localparam int WORD_W = NUM_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startStb,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              oddParity,
  output logic              txLine,
  output logic              busy
);
  txCtl_t ctl;
  logic   lastByte;

  sertx_control #(.CLKS_PER_BIT(CLKS_PER_BIT)) ctrl_i (
    .clk(clk), .rst(rst), .startStb(startStb), .lastByte(lastByte),
    .ctl(ctl), .busy(busy)
  );

  sertx_datapath #(.NUM_BYTES(NUM_BYTES)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .wordIn(wordIn), .oddParity(oddParity),
    .lastByte(lastByte), .txLine(txLine)
  );
endmodule

// File: tb/serial_word_tx_tb_top.sv
module serial_word_tx_tb_top;
  localparam int C  = 4;
  localparam int NB = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startStb = 1'b0;
  logic [63:0] wordIn = '0;
  logic        oddParity = 1'b0;
  logic        txLine, busy;

  int tests = 0, fails = 0, cyc = 0;
  logic [10:0] expQ [$];   // {odd, first, parity, byte}

  always #2 clk = ~clk;    // 250 MHz
  always @(posedge clk) cyc++;

  serial_word_tx #(.CLKS_PER_BIT(C), .NUM_BYTES(NB)) dut_i (
    .clk(clk), .rst(rst), .startStb(startStb), .wordIn(wordIn),
    .oddParity(oddParity), .txLine(txLine), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [63:0] w, input logic odd);
    @(negedge clk);
    for (int b = 0; b < NB; b++) begin
      logic [7:0] by;
      by = w[b*8 +: 8];
      expQ.push_back({odd, (b == 0), (^by) ^ odd, by});
    end
    wordIn = w; oddParity = odd; startStb = 1'b1;
    @(negedge clk);
    startStb = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    repeat (2 * C) @(negedge clk);
    check(expQ.size() == 0, "R3 all frames seen", expQ.size(), 0);
  endtask

  // monitor: rebuild frames from the line and compare with the scoreboard
  initial begin
    logic prev = 1'b1;
    int lastStart = 0;
    forever begin
      @(negedge clk);
      if (rst) begin prev = 1'b1; continue; end
      if (prev && !txLine) begin
        logic [10:0] got;
        logic stBit;
        int sc;
        sc = cyc;
        repeat (C / 2) @(negedge clk);
        stBit = txLine;
        for (int k = 0; k < 11; k++) begin
          repeat (C) @(negedge clk);
          got[k] = txLine;
        end
        if (expQ.size() == 0) begin
          check(1'b0, "R7 unexpected frame", got, 0);
        end else begin
          logic [10:0] e;
          e = expQ.pop_front();
          check(got[7:0] == e[7:0] && stBit == 1'b0, "R2/R3 data byte and start bit",
                {stBit, got[7:0]}, {1'b0, e[7:0]});
          check(got[9] && got[10], "R2 two stop bits", got[10:9], 2'b11);
          if (e[10]) check(got[8] == e[8], "R5 odd parity bit", got[8], e[8]);
          else       check(got[8] == e[8], "R4 even parity bit", got[8], e[8]);
          if (!e[9]) check(sc - lastStart == 12 * C, "R3 back-to-back spacing",
                           sc - lastStart, 12 * C);
        end
        lastStart = sc;
        prev = got[10];
      end else begin
        prev = txLine;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(txLine == 1'b1 && busy == 1'b0, "R1 during reset", {txLine, busy}, 2'b10);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(txLine == 1'b1 && busy == 1'b0, "R1 after reset", {txLine, busy}, 2'b10);

    // ramp word, even parity, with busy window timing
    sendWord(64'h8877_6655_4433_2211, 1'b0);
    check(busy == 1'b1, "R8 busy rises", busy, 1);
    repeat (NB * 12 * C - 1) @(negedge clk);
    check(busy == 1'b1, "R8 busy last cycle", busy, 1);
    @(negedge clk);
    check(busy == 1'b0 && txLine == 1'b1, "R8 busy falls, line rests", {busy, txLine}, 2'b01);
    waitIdle();

    sendWord(64'h0, 1'b0); waitIdle();
    sendWord(64'h0, 1'b1); waitIdle();
    sendWord(64'hFFFF_FFFF_FFFF_FFFF, 1'b0); waitIdle();
    sendWord(64'hFFFF_FFFF_FFFF_FFFF, 1'b1); waitIdle();
    sendWord(64'hF0E1_D2C3_B4A5_9687, 1'b1); waitIdle();

    // R6 / R7: disturb inputs during transfer
    sendWord(64'h55AA_55AA_55AA_55AA, 1'b1);
    wordIn = 64'h1234_5678_9ABC_DEF0; oddParity = 1'b0;
    repeat (50) @(negedge clk);
    startStb = 1'b1; wordIn = 64'hDEAD_BEEF_0BAD_F00D;
    @(negedge clk); startStb = 1'b0;
    check(busy == 1'b1, "R7 transfer continues", busy, 1);
    waitIdle();

    sendWord(64'hAA55_AA55_AA55_AA55, 1'b0); waitIdle();

    for (int i = 0; i < 30 * C; i++) begin
      @(negedge clk);
      if (txLine !== 1'b1 || busy !== 1'b0) begin
        check(1'b0, "R8 idle line", {txLine, busy}, 2'b10);
        break;
      end
    end
    check(expQ.size() == 0, "R7 no pending frames", expQ.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule